// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the word address used inside a synchronous burst memory. A base address is captured whenever one of two active-low address strobes is accepted on a rising clock edge. From then on, the two least significant address bits walk a four-beat wrapping burst under the control of an active-low advance input, while the upper bits stay fixed.

The processor strobe has priority over the controller strobe. It is gated by an active-low chip enable; the controller strobe is not gated. A mode input chooses the burst order, either XOR-interleaved or linear, and is latched once after reset. The outputs are the current full address, a flag for an accepted strobe, and the source of that strobe, which a write path downstream needs to tell the two kinds of access apart.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is zero and stb_acc_o and stb_src_o are 0, whatever the other inputs do.
- R2: When proc_stb_ni=0 and cs1_n_i=0 at a rising edge, addr_o equals the sampled addr_i after that edge, and stb_acc_o=1 with stb_src_o=1 (processor) for that cycle.
- R3: When ctrl_stb_ni=0 at a rising edge and the processor strobe is not accepted, addr_o loads addr_i, stb_acc_o=1 and stb_src_o=0 (controller), for either value of cs1_n_i.
- R4: With both strobes low and cs1_n_i=0, only the processor strobe is recognised: stb_src_o=1.
- R5: With cs1_n_i=1, proc_stb_ni=0 is ignored. If ctrl_stb_ni=1, addr_o keeps its value and stb_acc_o=0 in the next cycle.
- R6: With order_sel_i=1 latched (interleaved), beat k of a burst carries low bits base XOR k. Base 01 gives 01,00,11,10, and base 10 gives 10,11,00,01.
- R7: With order_sel_i=0 latched (linear), beat k carries low bits (base+k) mod 4, so base 11 gives 11,00,01,10.
- R8: With no strobe accepted, adv_ni=1 holds addr_o and adv_ni=0 steps to the next beat. stb_acc_o is 0 in any cycle without an accepted strobe.
- R9: An advance after the fourth beat returns the low bits to the base value.
- R10: adv_ni is ignored at an edge where a strobe loads: the first beat is the loaded address itself.
- R11: order_sel_i is sampled only at the first rising edge after reset release. Later changes have no effect until the next reset.
- R12: addr_o bits above bit 1 change only when a strobe loads. A linear wrap from 11 to 00 does not carry into bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_n_i | input | 1 | First chip enable, active low; gates the processor strobe |
| proc_stb_ni | input | 1 | Processor address strobe, active low, priority |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | 1 = interleaved, 0 = linear; latched after reset |
| addr_i | input | ADDR_W | Base address sampled on an accepted strobe |
| addr_o | output | ADDR_W | Current burst address |
| stb_acc_o | output | 1 | A strobe was accepted at the last edge |
| stb_src_o | output | 1 | 1 = processor, 0 = controller; 0 when nothing was accepted |

## Verification
Two functions can fall in the same cycle here. Strobe arbitration can coincide with itself, when both strobes are low together with the chip enable. The load can coincide with a burst advance, when a strobe arrives while adv_ni is low. The vector table drives both strobes together with the chip enable asserted and then deasserted, and it starts new bursts with adv_ni low. The bench judges the result from the source flag and from a first beat equal to the new base rather than base plus one.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;
  typedef enum logic {SRC_CTRL = 1'b0, SRC_PROC = 1'b1} src_e;

  function automatic logic [BEAT_W-1:0] beat_addr(order_e ord,
                                                  logic [BEAT_W-1:0] base,
                                                  logic [BEAT_W-1:0] idx);
    return (ord == ORD_XOR) ? (base ^ idx) : (base + idx);
  endfunction
endpackage

// File: rtl/bsq_strobe_arb.sv
module bsq_strobe_arb
  import burst_seq_pkg::*;
(
  input  logic cs1_n_i,
  input  logic proc_stb_ni,
  input  logic ctrl_stb_ni,
  output logic load_o,
  output src_e src_o
);
  logic proc_ok, ctrl_ok;

  assign proc_ok = ~proc_stb_ni & ~cs1_n_i;  // chip enable gates only the processor strobe
  assign ctrl_ok = ~ctrl_stb_ni;
  assign load_o  = proc_ok | ctrl_ok;
  assign src_o   = proc_ok ? SRC_PROC : SRC_CTRL;
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] base_i,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  output logic [BEAT_W-1:0] beat_o
);
  order_e            mode_q;
  logic              mode_vld_q;
  logic [BEAT_W-1:0] base_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= ORD_LINEAR;
      mode_vld_q <= 1'b0;
    end else if (!mode_vld_q) begin
      mode_q     <= order_e'(order_sel_i);
      mode_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (!adv_ni) begin
      idx_q  <= idx_q + 1'b1;  // natural wrap after the last beat
    end
  end

  assign beat_o = beat_addr(mode_q, base_q, idx_q);

  assert_load_first_beat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == $past(base_i));

  assert_suspend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o));

  assert_linear_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && mode_vld_q && mode_q == ORD_LINEAR)
      |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

  assert_mode_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_vld_q |=> $stable(mode_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs1_n_i,
  input  logic              proc_stb_ni,
  input  logic              ctrl_stb_ni,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              stb_acc_o,
  output logic              stb_src_o
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  logic               load;
  src_e               src;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  beat;
  logic               acc_q;
  src_e               src_q;

  bsq_strobe_arb u_arb (
    .cs1_n_i    (cs1_n_i),
    .proc_stb_ni(proc_stb_ni),
    .ctrl_stb_ni(ctrl_stb_ni),
    .load_o     (load),
    .src_o      (src)
  );

  bsq_beat_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (addr_i[BEAT_W-1:0]),
    .adv_ni     (adv_ni),
    .order_sel_i(order_sel_i),
    .beat_o     (beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      acc_q   <= 1'b0;
      src_q   <= SRC_CTRL;
    end else begin
      if (load) upper_q <= addr_i[ADDR_W-1:BEAT_W];
      acc_q <= load;
      src_q <= load ? src : SRC_CTRL;
    end
  end

  assign addr_o    = {upper_q, beat};
  assign stb_acc_o = acc_q;
  assign stb_src_o = src_q;

  assert_load_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (addr_o == $past(addr_i)) && stb_acc_o);

  assert_proc_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_stb_ni && !cs1_n_i) |=> stb_src_o);

  assert_proc_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs1_n_i && ctrl_stb_ni) |=> !stb_acc_o && !stb_src_o);

  assert_ctrl_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_stb_ni && (cs1_n_i || proc_stb_ni)) |=> stb_acc_o && !stb_src_o);

  assert_upper_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int unsigned AW = 17;
  localparam int unsigned NV = 14;
  localparam int unsigned VW = 4 + 2*AW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs1_n = 1'b1, ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, osel = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_q;
  logic          acc, src;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs1_n_i(cs1_n), .proc_stb_ni(ps_n),
    .ctrl_stb_ni(cs_n), .adv_ni(adv_n), .order_sel_i(osel), .addr_i(addr),
    .addr_o(addr_q), .stb_acc_o(acc), .stb_src_o(src)
  );

  // {cs1_n, ps_n, cs_n, adv_n, addr, exp_addr, exp_acc, exp_src}; interleaved mode
  localparam logic [VW-1:0] VECS [NV] = '{
    {4'b0010, 17'h0ABC5, 17'h0ABC5, 2'b11},  // R2 R10 proc load, adv ignored
    {4'b1110, 17'h1FFFF, 17'h0ABC4, 2'b00},  // R6 beat1
    {4'b1110, 17'h1FFFF, 17'h0ABC7, 2'b00},  // R6 beat2
    {4'b1111, 17'h00000, 17'h0ABC7, 2'b00},  // R8 suspend
    {4'b1110, 17'h00000, 17'h0ABC6, 2'b00},  // R6 beat3
    {4'b1110, 17'h00000, 17'h0ABC5, 2'b00},  // R9 wrap
    {4'b0001, 17'h12346, 17'h12346, 2'b11},  // R4 both strobes
    {4'b1110, 17'h00000, 17'h12347, 2'b00},  // R6 base 10 beat1
    {4'b1011, 17'h0FFFC, 17'h12347, 2'b00},  // R5 proc gated
    {4'b1001, 17'h05551, 17'h05551, 2'b10},  // R3 R5 ctrl with cs1 high
    {4'b1110, 17'h00000, 17'h05550, 2'b00},  // R6
    {4'b0100, 17'h1F002, 17'h1F002, 2'b10},  // R3 R10 ctrl load, adv ignored
    {4'b1110, 17'h00000, 17'h1F003, 2'b00},  // R6
    {4'b1110, 17'h00000, 17'h1F000, 2'b00}   // R6 R12
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic c1, logic p, logic c, logic a, logic [AW-1:0] ad);
    cs1_n = c1; ps_n = p; cs_n = c; adv_n = a; addr = ad;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 17'h1AAAA);
    #1;
    check("R1 reset addr", 32'(addr_q), 32'h0);
    check("R1 reset acc", 32'(acc), 32'h0);
    check("R1 reset src", 32'(src), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      drive(v[VW-1], v[VW-2], v[VW-3], v[VW-4], v[VW-5 -: AW]);
      step();
      check($sformatf("vec%0d addr R2-R12", i), 32'(addr_q), 32'(v[AW+1:2]));
      check($sformatf("vec%0d acc R8", i), 32'(acc), 32'(v[1]));
      check($sformatf("vec%0d src R4", i), 32'(src), 32'(v[0]));
    end

    // R1: async reset from non-zero state
    rst_n = 1'b0;
    osel  = 1'b0;
    #1;
    check("R1 mid-run reset addr", 32'(addr_q), 32'h0);
    check("R1 mid-run reset acc", 32'(acc), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h0);
    step();                            // mode latched linear here
    check("R11 idle after reset", 32'(addr_q), 32'h0);
    osel = 1'b1;                       // must be ignored
    drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h00A53);
    step();
    check("R7 linear load base 11", 32'(addr_q), 32'h0A53);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
    step();
    check("R7 R11 R12 linear beat1", 32'(addr_q), 32'h0A50);
    step();
    check("R7 linear beat2", 32'(addr_q), 32'h0A51);
    step();
    check("R7 linear beat3", 32'(addr_q), 32'h0A52);
    step();
    check("R9 linear wrap", 32'(addr_q), 32'h0A53);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h0);
    step();
    check("R8 linear suspend", 32'(addr_q), 32'h0A53);
    check("R8 no strobe acc", 32'(acc), 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end
endmodule